// File: doc/BRIEF.md
# PCI Configuration Cycle Router

This block sits on the primary side of a PCI-to-PCI bridge. It inspects the address phase of an incoming configuration cycle and decides what the bridge should do with it. When the address-phase strobe is high, the block samples the 32-bit address, the 4-bit bus command and the bridge's secondary and subordinate bus numbers. It then takes the bus-number field from address bits [23:16] and compares it with those two numbers.

A cycle aimed at the bus directly behind the bridge is rewritten as a Type 0 cycle. The device number in address bits [15:11] becomes a one-hot select line on the upper address bits, or the cycle becomes a broadcast special cycle. A cycle aimed at a bus further downstream passes through unchanged as Type 1. Every other cycle is ignored. The decision and the rewritten secondary address and command are registered and held for the forwarding logic until it pulses a clear input.

A converted Type 0 cycle also raises a master-abort flag when no device line can be selected. It raises a single-data-phase limit and a delayed-request indication, because such a cycle is limited to one 32-bit transfer and is completed as a delayed transaction.

Top module: `cfg_cycle_router`

## Requirements
- R1: With strobe high, address bits [1:0] = 01b, a configuration command and a bus number equal to the secondary bus number, a device number d in 0..15 gives action 1 (Type 0). The secondary address is then {16-bit one-hot with only bit d set, 5'b0, address[10:2], 2'b00}, so address line 16+d is driven, and the secondary command equals the input command.
- R2: Under the same conditions, device numbers 16..31 give action 1 with secondary address bits [31:16] all zero and the master-abort output high, except for the special-cycle case of R3. Master abort is low for device numbers 0..15 and for all other actions.
- R3: Device number 31 with register field address[7:2] = 0 and command 1011b gives action 3 (special cycle). Secondary command is 0001b, secondary address is {16'h0, 5'b0, address[10:2], 2'b00}, and master abort is low. The same address with command 1010b gives action 0.
- R4: The cycle is treated as Type 1 only when address bits [1:0] = 01b. Any other value gives action 0.
- R5: Action 2 (forward unchanged) is chosen when the bus number is strictly greater than the secondary bus number and less than or equal to the subordinate bus number. The secondary address and command then equal the inputs exactly. A bus number that is below the secondary bus number or above the subordinate bus number gives action 0.
- R6: Only configuration read (1010b) and configuration write (1011b) are acted on. Every other command gives action 0.
- R7: The single-data-phase output and the delayed-request output are high exactly when the action is 1, and low for actions 0, 2 and 3.
- R8: Action 0 (ignore) leaves the secondary address and command at their previous values and drives master abort, single-data-phase and delayed-request low.
- R9: The decision appears on the outputs one clock after the strobe sample and holds while the strobe and clear inputs are low. A clear pulse without the strobe sets the action to 0 and drops the three flags, and leaves the secondary address and command unchanged. If the strobe and clear are high together, the strobe wins.
- R10: After reset, the action is 0, the secondary address and command are 0, and all flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_valid | input | 1 | Address-phase strobe; inputs are sampled while high |
| addr_in | input | 32 | Primary address-phase address |
| cmd_in | input | 4 | Primary bus command |
| sec_bus | input | 8 | Secondary bus number |
| sub_bus | input | 8 | Subordinate bus number |
| clr | input | 1 | Clears the held decision |
| action | output | 2 | 0 ignore, 1 Type 0, 2 Type 1 pass-through, 3 special cycle |
| sec_addr | output | 32 | Translated secondary address |
| sec_cmd | output | 4 | Translated secondary command |
| mabort | output | 1 | No device line selected; cycle will master-abort |
| single_xfer | output | 1 | Limit the cycle to one 32-bit data phase |
| delayed_req | output | 1 | Handle the cycle as a delayed transaction |

## Verification
Every result is registered once, so all outputs for a strobe sampled at one rising edge are due right after that edge. The bench drives inputs on the falling edge, holds the strobe for exactly one rising edge, and compares every output at the next falling edge. Hold and clear behaviour is checked the same way. After strobe-free cycles with the inputs scrambled, the outputs are checked again one falling edge after a clear pulse. For the ignore cases, the bench carries the last expected secondary address and command forward as the expected value.

// File: rtl/cfgr_pkg.sv
package cfgr_pkg;

    localparam int ADDR_W  = 32;
    localparam int CMD_W   = 4;
    localparam int BUS_W   = 8;
    localparam int DEV_W   = 5;
    localparam int LINES_W = 16;

    localparam logic [CMD_W-1:0] CMD_CFG_RD  = 4'b1010;
    localparam logic [CMD_W-1:0] CMD_CFG_WR  = 4'b1011;
    localparam logic [CMD_W-1:0] CMD_SPECIAL = 4'b0001;

    typedef enum logic [1:0] {
        ACT_IGNORE  = 2'd0,
        ACT_TYPE0   = 2'd1,
        ACT_TYPE1   = 2'd2,
        ACT_SPECIAL = 2'd3
    } act_e;

    typedef struct packed {
        act_e              act;
        logic [ADDR_W-1:0] addr;
        logic [CMD_W-1:0]  cmd;
        logic              mabort;
        logic              single;
        logic              dreq;
    } route_t;

endpackage

// File: rtl/cfgr_idsel_decode.sv
module cfgr_idsel_decode #(
    parameter int DEV_W   = 5,
    parameter int LINES_W = 16
) (
    input  logic [DEV_W-1:0]   dev,
    output logic [LINES_W-1:0] lines,
    output logic               any_line
);

    for (genvar i = 0; i < LINES_W; i++) begin : g_line
        assign lines[i] = (dev == DEV_W'(i));
    end

    assign any_line = (dev < DEV_W'(LINES_W));

    always_comb begin
        if (!$isunknown(dev)) begin
            AST_LINE_COUNT: assert ($countones(lines) == (any_line ? 1 : 0)); // R1
        end
    end

endmodule

// File: rtl/cfgr_bus_window.sv
module cfgr_bus_window #(
    parameter int BUS_W = 8
) (
    input  logic [BUS_W-1:0] bus,
    input  logic [BUS_W-1:0] sec,
    input  logic [BUS_W-1:0] sub,
    output logic             is_local,
    output logic             is_below
);

    logic above_sec;
    logic within_sub;

    always_comb begin
        above_sec  = (bus > sec);
        within_sub = (bus <= sub);
        is_local   = (bus == sec);
        is_below   = above_sec && within_sub;
    end

    always_comb begin
        if (!$isunknown({bus, sec, sub})) begin
            AST_WINDOW_EXCL: assert (!(is_local && is_below)); // R5
        end
    end

endmodule

// File: rtl/cfg_cycle_router.sv
module cfg_cycle_router
    import cfgr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_valid,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [CMD_W-1:0]  cmd_in,
    input  logic [BUS_W-1:0]  sec_bus,
    input  logic [BUS_W-1:0]  sub_bus,
    input  logic              clr,
    output logic [1:0]        action,
    output logic [ADDR_W-1:0] sec_addr,
    output logic [CMD_W-1:0]  sec_cmd,
    output logic              mabort,
    output logic              single_xfer,
    output logic              delayed_req
);

    localparam int BUS_LSB = 16;
    localparam int DEV_LSB = 11;
    localparam int REG_LSB = 2;
    localparam int REG_W   = 6;
    localparam int LOW_W   = DEV_LSB - REG_LSB;
    localparam int PAD_W   = ADDR_W - LINES_W - DEV_W - LOW_W - 2;

    route_t st_d, st_q;

    logic [BUS_W-1:0]   bus_num;
    logic [DEV_W-1:0]   dev_num;
    logic [REG_W-1:0]   reg_num;
    logic [LOW_W-1:0]   fn_reg;
    logic [LINES_W-1:0] dev_lines;
    logic               dev_hit;
    logic               win_local;
    logic               win_below;
    logic               is_type1;
    logic               is_cfg;
    logic               is_bcast;

    assign bus_num = addr_in[BUS_LSB +: BUS_W];
    assign dev_num = addr_in[DEV_LSB +: DEV_W];
    assign reg_num = addr_in[REG_LSB +: REG_W];
    assign fn_reg  = addr_in[REG_LSB +: LOW_W];

    cfgr_idsel_decode #(
        .DEV_W   (DEV_W),
        .LINES_W (LINES_W)
    ) i_idsel (
        .dev      (dev_num),
        .lines    (dev_lines),
        .any_line (dev_hit)
    );

    cfgr_bus_window #(
        .BUS_W (BUS_W)
    ) i_window (
        .bus      (bus_num),
        .sec      (sec_bus),
        .sub      (sub_bus),
        .is_local (win_local),
        .is_below (win_below)
    );

    always_comb begin
        is_type1 = (addr_in[1:0] == 2'b01);
        is_cfg   = (cmd_in == CMD_CFG_RD) || (cmd_in == CMD_CFG_WR);
        is_bcast = (dev_num == {DEV_W{1'b1}}) && (reg_num == '0);

        st_d = st_q;
        if (addr_valid) begin
            st_d.act    = ACT_IGNORE;
            st_d.mabort = 1'b0;
            st_d.single = 1'b0;
            st_d.dreq   = 1'b0;
            if (is_type1 && is_cfg) begin
                if (win_local) begin
                    if (is_bcast) begin
                        if (cmd_in == CMD_CFG_WR) begin
                            st_d.act  = ACT_SPECIAL;
                            st_d.addr = {{LINES_W{1'b0}}, {PAD_W{1'b0}},
                                         {DEV_W{1'b0}}, fn_reg, 2'b00};
                            st_d.cmd  = CMD_SPECIAL;
                        end
                    end else begin
                        st_d.act    = ACT_TYPE0;
                        st_d.addr   = {dev_lines, {PAD_W{1'b0}},
                                       {DEV_W{1'b0}}, fn_reg, 2'b00};
                        st_d.cmd    = cmd_in;
                        st_d.mabort = !dev_hit;
                        st_d.single = 1'b1;
                        st_d.dreq   = 1'b1;
                    end
                end else if (win_below) begin
                    st_d.act  = ACT_TYPE1;
                    st_d.addr = addr_in;
                    st_d.cmd  = cmd_in;
                end
            end
        end else if (clr) begin
            st_d.act    = ACT_IGNORE;
            st_d.mabort = 1'b0;
            st_d.single = 1'b0;
            st_d.dreq   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{act: ACT_IGNORE, addr: '0, cmd: '0,
                      mabort: 1'b0, single: 1'b0, dreq: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign action      = st_q.act;
    assign sec_addr    = st_q.addr;
    assign sec_cmd     = st_q.cmd;
    assign mabort      = st_q.mabort;
    assign single_xfer = st_q.single;
    assign delayed_req = st_q.dreq;

    AST_TYPE0_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (action == 2'd1 && !mabort) |-> ($countones(sec_addr[31:16]) == 1)); // R1
    AST_ABORT_NO_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        mabort |-> (action == 2'd1 && sec_addr[31:16] == '0)); // R2
    AST_SPECIAL_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        (action == 2'd3) |-> (sec_cmd == 4'b0001 && sec_addr[31:16] == '0 && !mabort)); // R3
    AST_PASS_UNCHANGED: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && !(addr_in[1:0] == 2'b01)) |=> (action == 2'd0)); // R4
    AST_LIMIT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (single_xfer || delayed_req) |-> (action == 2'd1 && single_xfer && delayed_req)); // R7
    AST_IGNORE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |=> (action != 2'd0 || ($stable(sec_addr) && $stable(sec_cmd)))); // R8
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_valid && !clr) |=> ($stable(action) && $stable(sec_addr) && $stable(mabort))); // R9
    AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !addr_valid) |=> (action == 2'd0 && $stable(sec_addr) && !delayed_req)); // R9

endmodule

// File: tb/test_cfg_cycle_router.sv
`timescale 1ns/1ps
module test_cfg_cycle_router;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_valid = 1'b0;
    logic [31:0] addr_in = '0;
    logic [3:0]  cmd_in = '0;
    logic [7:0]  sec_bus = 8'd4;
    logic [7:0]  sub_bus = 8'd9;
    logic        clr = 1'b0;
    logic [1:0]  action;
    logic [31:0] sec_addr;
    logic [3:0]  sec_cmd;
    logic        mabort;
    logic        single_xfer;
    logic        delayed_req;

    int checks = 0;
    int fails  = 0;

    logic [1:0]  e_act;
    logic [31:0] e_addr;
    logic [3:0]  e_cmd;
    logic        e_mab, e_sgl, e_drq;
    string       e_tag;

    always #2.5 clk = ~clk;

    cfg_cycle_router i_cfg_cycle_router (
        .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .addr_in(addr_in),
        .cmd_in(cmd_in), .sec_bus(sec_bus), .sub_bus(sub_bus), .clr(clr),
        .action(action), .sec_addr(sec_addr), .sec_cmd(sec_cmd), .mabort(mabort),
        .single_xfer(single_xfer), .delayed_req(delayed_req)
    );

    task automatic compare(input string tag);
        checks++;
        if (action !== e_act || sec_addr !== e_addr || sec_cmd !== e_cmd ||
            mabort !== e_mab || single_xfer !== e_sgl || delayed_req !== e_drq) begin
            fails++;
            $display("FAIL %s: got act=%0d addr=%h cmd=%h mab=%b sgl=%b drq=%b, expected act=%0d addr=%h cmd=%h mab=%b sgl=%b drq=%b",
                     tag, action, sec_addr, sec_cmd, mabort, single_xfer, delayed_req,
                     e_act, e_addr, e_cmd, e_mab, e_sgl, e_drq);
        end
    endtask

    task automatic predict(input logic [31:0] a, input logic [3:0] c);
        int bus, dev, rg, sec, sub;
        logic cfg;
        bus = int'(a[23:16]);
        dev = int'(a[15:11]);
        rg  = int'(a[7:2]);
        sec = int'(sec_bus);
        sub = int'(sub_bus);
        cfg = (c == 4'hA) || (c == 4'hB);
        e_act = 2'd0; e_mab = 1'b0; e_sgl = 1'b0; e_drq = 1'b0;
        if (a[1:0] != 2'b01) begin
            e_tag = "R4 type mismatch";
        end else if (!cfg) begin
            e_tag = "R6 non-config command";
        end else if (bus == sec) begin
            if (dev == 31 && rg == 0) begin
                e_tag = "R3 special cycle";
                if (c == 4'hB) begin
                    e_act  = 2'd3;
                    e_cmd  = 4'h1;
                    e_addr = a[10:2] * 4;
                end
            end else begin
                e_tag  = (dev < 16) ? "R1 idsel line" : "R2 no line abort";
                e_act  = 2'd1;
                e_cmd  = c;
                e_addr = ((dev < 16) ? (32'h1 << (16 + dev)) : 32'h0) + a[10:2] * 4;
                e_mab  = (dev >= 16);
                e_sgl  = 1'b1;
                e_drq  = 1'b1;
            end
        end else if (bus > sec && bus <= sub) begin
            e_tag  = "R5 pass-through";
            e_act  = 2'd2;
            e_addr = a;
            e_cmd  = c;
        end else begin
            e_tag = "R5/R8 outside window";
        end
    endtask

    task automatic strobe(input logic [31:0] a, input logic [3:0] c);
        addr_in = a;
        cmd_in  = c;
        addr_valid = 1'b1;
        predict(a, c);
        @(posedge clk);
        @(negedge clk);
        addr_valid = 1'b0;
        addr_in = ~a;
        cmd_in  = 4'h0;
        compare({e_tag, " (R7 R8 R9)"});
    endtask

    initial begin
        e_act = 2'd0; e_addr = '0; e_cmd = '0; e_mab = 1'b0; e_sgl = 1'b0; e_drq = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare("R10 reset state");

        for (int dev = 0; dev < 32; dev++) begin
            for (int rs = 0; rs < 2; rs++) begin
                for (int ci = 0; ci < 2; ci++) begin
                    logic [31:0] a;
                    a = {8'h5A, 8'd4, 5'(dev), 3'(dev % 8), (rs == 0) ? 6'h00 : 6'h15, 2'b01};
                    strobe(a, ci == 0 ? 4'hA : 4'hB);
                end
            end
        end

        for (int b = 0; b < 16; b++) begin
            for (int ci = 0; ci < 2; ci++) begin
                strobe({8'h3C, 8'(b), 5'd7, 3'd2, 6'h09, 2'b01}, ci == 0 ? 4'hA : 4'hB);
            end
        end

        for (int lo = 0; lo < 4; lo++) begin
            strobe({8'h00, 8'd4, 5'd3, 3'd1, 6'h02, 2'(lo)}, 4'hB);
            strobe({8'h00, 8'd6, 5'd3, 3'd1, 6'h02, 2'(lo)}, 4'hA);
        end

        for (int c = 0; c < 16; c++) begin
            strobe({8'h00, 8'd4, 5'd2, 3'd0, 6'h01, 2'b01}, 4'(c));
            strobe({8'h00, 8'd8, 5'd2, 3'd0, 6'h01, 2'b01}, 4'(c));
        end

        sec_bus = 8'd0; sub_bus = 8'd255;
        strobe({8'h00, 8'd255, 5'd1, 3'd0, 6'h00, 2'b01}, 4'hA);
        strobe({8'h00, 8'd0, 5'd15, 3'd7, 6'h3F, 2'b01}, 4'hB);

        for (int k = 0; k < 6; k++) begin
            addr_in = 32'hFFFF_0001 ^ (k * 32'h0101_0100);
            cmd_in  = 4'hB;
            @(negedge clk);
        end
        compare("R9 hold without strobe");

        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        e_act = 2'd0; e_mab = 1'b0; e_sgl = 1'b0; e_drq = 1'b0;
        compare("R9 clear pulse");

        clr = 1'b1;
        strobe({8'h00, 8'd0, 5'd4, 3'd3, 6'h08, 2'b01}, 4'hA);
        clr = 1'b0;
        compare("R9 strobe beats clear");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, got timeout, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule